// File: doc/BRIEF.md
# Radix-4 Recoded Signed Multiplier

This block multiplies two two's-complement operands of parameterised widths and returns the full-width signed product. The multiplier operand is recoded into radix-4 signed digits. Each digit selects one multiple of the multiplicand: zero, plus or minus one times, or plus or minus two times. This roughly halves the number of addends compared with one AND-gated row per multiplier bit.

The selected multiples are weighted by four per digit position and sign-extended to the product width. Negative multiples use an inverted row plus a separate carry bit at the row's weight. All rows are accumulated in modular arithmetic of width A_W+B_W, so the sign comes out right without any unsigned sub-expression.

A caller presents both operands with a valid strobe. The product and its valid flag come out of a register one clock later. When no strobe is given, the product register holds its last value.

Top module: `booth_mul`

## Requirements
- R1: The multiplier is extended by an implicit 0 below bit 0 and sign-extended to an even width B_EW. It is scanned in ceil(B_W/2) three-bit windows, where window k covers extended bits [2k+2:2k] and overlaps its neighbour by one bit. Odd B_W gives correct products.
- R2: Each window (high, mid, low) selects one addend. 000 and 111 select 0. 001 and 010 select +a. 011 selects +2a. 100 selects -2a. 101 and 110 select -a. At most one magnitude is chosen, and the negate flag is never set with a zero magnitude.
- R3: prod_o is A_W+B_W bits wide and equals the signed product of the captured operands for every pair. This includes most-negative times most-negative, which gives the positive value 2^(A_W+B_W-2).
- R4: A product captured with in_valid_i high appears on prod_o, with out_valid_o high, exactly one clock later.
- R5: In a cycle after in_valid_i was low, out_valid_o is low and prod_o keeps its previous value, whatever the operand inputs carried.
- R6: While rst_ni is low, out_valid_o is 0 and prod_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| in_valid_i | input | 1 | operands valid strobe |
| mcand_i | input | A_W | signed multiplicand |
| mplier_i | input | B_W | signed multiplier |
| out_valid_o | output | 1 | product valid, one cycle after the strobe |
| prod_o | output | A_W+B_W | signed product |

## Verification
Every result is due one clock after the edge that captures its operands. The bench drives operands on the falling edge and checks the previous pair's product on the next falling edge, so each check falls half a period after the register updates. Two instances are swept exhaustively in one stream: an 8x8 instance and a 5x7 instance with an odd multiplier width. After the sweep, cycles with the strobe low and changed operands check that the valid flag drops and the product holds.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef struct packed {
    logic neg;
    logic two;
    logic one;
  } booth_sel_t;

  // window bits: {high, mid, low}
  function automatic booth_sel_t booth_decode(input logic [2:0] win);
    booth_sel_t s;
    s = '0;
    case (win)
      3'b001, 3'b010: s.one = 1'b1;
      3'b011:         s.two = 1'b1;
      3'b100: begin s.two = 1'b1; s.neg = 1'b1; end
      3'b101, 3'b110: begin s.one = 1'b1; s.neg = 1'b1; end
      default:        s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
#(
  parameter int B_W = 8,
  localparam int B_EW = B_W + (B_W % 2),
  localparam int NG = B_EW / 2
) (
  input  logic [B_W-1:0] mplier_i,
  output booth_sel_t     sel_o [NG]
);

  logic signed [B_W-1:0] m_s;
  logic [B_EW:0]         ext;

  assign m_s = mplier_i;
  assign ext = {B_EW'(m_s), 1'b0};

  for (genvar k = 0; k < NG; k++) begin : g_win
    assign sel_o[k] = booth_decode(ext[2*k+2 -: 3]);

    always_comb begin
      if (!$isunknown(ext)) begin
        AST_MAG_ONEHOT: assert ($onehot0({sel_o[k].one, sel_o[k].two})); // R2
        AST_NEG_NONZERO: assert (!sel_o[k].neg || sel_o[k].one || sel_o[k].two); // R2
      end
    end
  end

endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
  import booth_pkg::*;
#(
  parameter int A_W = 8,
  parameter int PW = 16,
  parameter int SHIFT = 0
) (
  input  logic [A_W-1:0] mcand_i,
  input  booth_sel_t     sel_i,
  output logic [PW-1:0]  pp_o,
  output logic [PW-1:0]  carry_o
);

  logic signed [A_W-1:0] a_s;
  logic [PW-1:0]         a_ext, mag, row;

  assign a_s   = mcand_i;
  assign a_ext = PW'(a_s);

  always_comb begin
    if (sel_i.two)      mag = a_ext << 1;
    else if (sel_i.one) mag = a_ext;
    else                mag = '0;
    row = sel_i.neg ? ~mag : mag;
  end

  // -x = ~x + 1; the +1 rides at this row's weight
  assign pp_o    = row << SHIFT;
  assign carry_o = PW'(sel_i.neg) << SHIFT;

endmodule

// File: rtl/booth_sum.sv
module booth_sum #(
  parameter int PW = 16,
  parameter int NG = 4
) (
  input  logic [PW-1:0] pp_i    [NG],
  input  logic [PW-1:0] carry_i [NG],
  output logic [PW-1:0] sum_o
);

  logic [PW-1:0] acc [NG+1];

  assign acc[0] = '0;
  for (genvar k = 0; k < NG; k++) begin : g_acc
    assign acc[k+1] = acc[k] + pp_i[k] + carry_i[k];
  end
  assign sum_o = acc[NG];

endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_pkg::*;
#(
  parameter int A_W = 8,
  parameter int B_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [A_W-1:0]   mcand_i,
  input  logic [B_W-1:0]   mplier_i,
  output logic             out_valid_o,
  output logic [A_W+B_W-1:0] prod_o
);

  localparam int PW   = A_W + B_W;
  localparam int B_EW = B_W + (B_W % 2);
  localparam int NG   = B_EW / 2;

  booth_sel_t    sel   [NG];
  logic [PW-1:0] pp    [NG];
  logic [PW-1:0] carry [NG];
  logic [PW-1:0] sum;

  booth_recoder #(.B_W(B_W)) u_rec (
    .mplier_i (mplier_i),
    .sel_o    (sel)
  );

  for (genvar k = 0; k < NG; k++) begin : g_pp
    booth_pp_gen #(.A_W(A_W), .PW(PW), .SHIFT(2*k)) u_pp (
      .mcand_i (mcand_i),
      .sel_i   (sel[k]),
      .pp_o    (pp[k]),
      .carry_o (carry[k])
    );
  end

  booth_sum #(.PW(PW), .NG(NG)) u_sum (
    .pp_i    (pp),
    .carry_i (carry),
    .sum_o   (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      prod_o      <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) prod_o <= sum;
    end
  end

  // reference product, fully signed, for checking only
  logic signed [PW-1:0] ref_prod;
  assign ref_prod = $signed(mcand_i) * $signed(mplier_i);

  AST_PRODUCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> prod_o == $past(ref_prod)); // R3
  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o && $stable(prod_o)); // R5

endmodule

// File: tb/booth_mul_tb.sv
module booth_mul_tb;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] a8 = '0, b8 = '0;
  logic out_valid, out_valid_odd;
  logic [15:0] prod;
  logic [11:0] prod_odd;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  booth_mul #(.A_W(8), .B_W(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid),
    .mcand_i(a8), .mplier_i(b8), .out_valid_o(out_valid), .prod_o(prod));

  booth_mul #(.A_W(5), .B_W(7)) u_dut_odd (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid),
    .mcand_i(a8[4:0]), .mplier_i(b8[6:0]), .out_valid_o(out_valid_odd),
    .prod_o(prod_odd));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int exp8, exp_odd;
  int hold8, hold_odd;

  initial begin
    #10000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R6: reset state
    @(negedge clk);
    @(negedge clk);
    chk("R6 out_valid", int'(out_valid), 0);
    chk("R6 prod", int'(prod), 0);
    chk("R6 odd prod", int'(prod_odd), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // exhaustive streamed sweep; each result checked one clock later
    in_valid = 1'b1;
    for (int i = 0; i < 65536; i++) begin
      a8 = i[7:0];
      b8 = i[15:8];
      exp8    = int'($signed(a8)) * int'($signed(b8));
      exp_odd = int'($signed(a8[4:0])) * int'($signed(b8[6:0]));
      @(negedge clk);
      chk("R1 R2 R3 R4 prod 8x8", int'($signed(prod)), exp8);
      chk("R4 out_valid", int'(out_valid), 1);
      chk("R1 R3 prod odd 5x7", int'($signed(prod_odd)), exp_odd);
    end

    // R3: extreme corner pairs
    for (int c = 0; c < 4; c++) begin
      a8 = c[0] ? 8'h80 : 8'h7f;
      b8 = c[1] ? 8'h80 : 8'h7f;
      exp8 = int'($signed(a8)) * int'($signed(b8));
      @(negedge clk);
      chk("R3 corner", int'($signed(prod)), exp8);
    end
    chk("R3 most-neg squared", int'(prod), 16384);

    // R5: strobe low, operands changed
    hold8    = int'(prod);
    hold_odd = int'(prod_odd);
    in_valid = 1'b0;
    for (int j = 0; j < 8; j++) begin
      a8 = 8'(j * 37 + 5);
      b8 = 8'(j * 91 + 3);
      @(negedge clk);
      chk("R5 out_valid low", int'(out_valid), 0);
      chk("R5 prod held", int'(prod), hold8);
      chk("R5 odd prod held", int'(prod_odd), hold_odd);
    end

    // R4: one strobe after idle
    in_valid = 1'b1;
    a8 = 8'hf3;
    b8 = 8'h29;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R4 single strobe valid", int'(out_valid), 1);
    chk("R4 single strobe prod", int'($signed(prod)), -13 * 41);
    @(negedge clk);
    chk("R5 valid drops", int'(out_valid), 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule